// File: doc/BRIEF.md
# Three-Operand Integer ALU with Registered Result

This block is the execute-stage arithmetic unit of a 32-bit three-operand processor. Each cycle it may accept a first operand, a second operand that is taken either from a register value or from an already formed immediate, and a 4-bit function code. It computes one of thirteen operations and registers the result together with a valid flag. The register file, memory access, branching and immediate construction all live elsewhere.

The processor keeps no condition codes, so comparisons return their answer as a 0 or 1 in the result word, and the unit drives no carry, zero or overflow flags. Function codes 13 to 15 are not assigned. They raise an illegal-function output and give a zero result, so that the decoder can trap on them.

The output side is a two-state machine. `OUT_IDLE` means no result is held. `OUT_VALID` means the result register holds a fresh result. Transition `T_ACCEPT` enters `OUT_VALID` from either state when `in_valid` is high. Transition `T_DRAIN` enters `OUT_IDLE` from either state when `in_valid` is low. Reset forces `OUT_IDLE`.

Top module: `alu_top`

## Requirements
- R1: Function code 0 yields (first + second) mod 2^32, and code 1 yields (first - second) mod 2^32.
- R2: Code 2 yields 1 when first < second as unsigned numbers and 0 otherwise. Code 3 makes the same test on two's-complement values. Bits [31:1] of the result are zero for both codes.
- R3: Codes 4, 5, 6 and 7 yield the bitwise AND, OR, XOR and NOR of the two operands.
- R4: Code 8 shifts the first operand left with zero fill. Code 9 shifts it right with zero fill. Code 10 shifts it right with copies of bit 31. The shift amount is bits [4:0] of the second operand, and its higher bits have no effect.
- R5: Code 11 yields bits [7:0] of the first operand sign-extended to 32 bits. Code 12 yields bits [15:0] of the first operand sign-extended to 32 bits. The second operand has no effect on either code.
- R6: Codes 13, 14 and 15 set `res_illegal` to 1 and the result to 0. Codes 0 to 12 clear `res_illegal`.
- R7: When `use_imm` is 1 the second operand is `imm`, and `opb` has no effect. When `use_imm` is 0 the second operand is `opb`.
- R8: `res_valid` equals `in_valid` delayed by one clock edge. `res_data` and `res_illegal` load only on an edge where `in_valid` is 1, and otherwise keep their values.
- R9: While `rst_n` is low, `res_valid`, `res_data` and `res_illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and function code are valid this cycle |
| fn | input | 4 | Function code 0..15 |
| opa | input | 32 | First operand |
| opb | input | 32 | Register second operand |
| imm | input | 32 | Immediate second operand |
| use_imm | input | 1 | 1 selects `imm` as the second operand |
| res_valid | output | 1 | Result register holds a fresh result |
| res_data | output | 32 | Registered result |
| res_illegal | output | 1 | Registered illegal-function indication |

## Verification
Two functions meet in one cycle when a shift code is issued with `use_imm` high and an immediate whose bits above [4:0] are set, while `opb` carries a different amount. The bench drives exactly this, and the result is correct only if it reflects both the operand selection and the shift-amount masking. A second overlap is a cycle with `in_valid` low, issued right after an illegal code while the inputs change. That cycle is judged by the expectation that `res_valid` falls while `res_data` and `res_illegal` keep their previous values.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        FN_ADD  = 4'd0,
        FN_SUB  = 4'd1,
        FN_LTU  = 4'd2,
        FN_LTS  = 4'd3,
        FN_AND  = 4'd4,
        FN_OR   = 4'd5,
        FN_XOR  = 4'd6,
        FN_NOR  = 4'd7,
        FN_SHL  = 4'd8,
        FN_SHR  = 4'd9,
        FN_SHRA = 4'd10,
        FN_EXTB = 4'd11,
        FN_EXTH = 4'd12
    } alu_fn_e;

    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_VALID = 1'b1
    } out_state_e;

endpackage

// File: rtl/alu_arith.sv
// Adder, subtractor and both set-less-than comparisons share one subtraction.
module alu_arith #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [W-1:0] diff,
    output logic         lt_u,
    output logic         lt_s
);
    logic [W:0] wide_diff;

    always_comb begin
        sum       = a + b;
        wide_diff = {1'b0, a} - {1'b0, b};
        diff      = wide_diff[W-1:0];
        // A borrow out of the top bit means a < b unsigned.
        lt_u      = wide_diff[W];
        // Mixed signs decide directly; equal signs cannot overflow.
        lt_s      = (a[W-1] ^ b[W-1]) ? a[W-1] : wide_diff[W-1];
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r_and,
    output logic [W-1:0] r_or,
    output logic [W-1:0] r_xor,
    output logic [W-1:0] r_nor
);
    always_comb begin
        r_and = a & b;
        r_or  = a | b;
        r_xor = a ^ b;
        r_nor = ~(a | b);
    end
endmodule

// File: rtl/alu_shift.sv
// One right-shifting barrel serves all three shifts; a left shift is done by
// reversing the bit order around the barrel.
module alu_shift #(
    parameter int W   = 32,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   y
);
    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stg [0:SHW];
    logic         fill;

    generate
        for (genvar i = 0; i < W; i++) begin : g_rev
            assign rev_in[i]  = a[W-1-i];
            assign rev_out[i] = stg[SHW][W-1-i];
        end
    endgenerate

    assign fill   = arith & ~left & a[W-1];
    assign stg[0] = left ? rev_in : a;

    generate
        for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int D = 1 << s;
            assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][W-1:D]} : stg[s];
        end
    endgenerate

    assign y = left ? rev_out : stg[SHW];
endmodule

// File: rtl/alu_extend.sv
module alu_extend #(
    parameter int W  = 32,
    parameter int NB = 8,
    parameter int NH = 16
) (
    input  logic [NH-1:0] a_low,
    output logic [W-1:0]  ext_b,
    output logic [W-1:0]  ext_h
);
    always_comb begin
        ext_b = {{(W-NB){a_low[NB-1]}}, a_low[NB-1:0]};
        ext_h = {{(W-NH){a_low[NH-1]}}, a_low};
    end
endmodule

// File: rtl/alu_top.sv
module alu_top
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [FW-1:0] fn,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [W-1:0]  imm,
    input  logic          use_imm,
    output logic          res_valid,
    output logic [W-1:0]  res_data,
    output logic          res_illegal
);
    localparam int SHW = $clog2(W);
    localparam int NB  = 8;
    localparam int NH  = 16;

    logic [W-1:0] opnd_b;
    logic [W-1:0] sum, diff, r_and, r_or, r_xor, r_nor, r_shift, ext_b, ext_h;
    logic         lt_u, lt_s;
    logic         sh_left, sh_arith;
    logic [W-1:0] next_data;
    logic         next_illegal;

    out_state_e state_q, state_d;
    logic [W-1:0] data_q;
    logic         illegal_q;

    assign opnd_b   = use_imm ? imm : opb;
    assign sh_left  = (fn == FN_SHL);
    assign sh_arith = (fn == FN_SHRA);

    alu_arith #(.W(W)) u_arith (
        .a(opa), .b(opnd_b), .sum(sum), .diff(diff), .lt_u(lt_u), .lt_s(lt_s)
    );

    alu_logic #(.W(W)) u_logic (
        .a(opa), .b(opnd_b), .r_and(r_and), .r_or(r_or), .r_xor(r_xor), .r_nor(r_nor)
    );

    alu_shift #(.W(W), .SHW(SHW)) u_shift (
        .a(opa), .amt(opnd_b[SHW-1:0]), .left(sh_left), .arith(sh_arith), .y(r_shift)
    );

    alu_extend #(.W(W), .NB(NB), .NH(NH)) u_extend (
        .a_low(opa[NH-1:0]), .ext_b(ext_b), .ext_h(ext_h)
    );

    // Result selection
    always_comb begin
        next_data    = '0;
        next_illegal = 1'b0;
        unique case (alu_fn_e'(fn))
            FN_ADD:  next_data = sum;
            FN_SUB:  next_data = diff;
            FN_LTU:  next_data = {{(W-1){1'b0}}, lt_u};
            FN_LTS:  next_data = {{(W-1){1'b0}}, lt_s};
            FN_AND:  next_data = r_and;
            FN_OR:   next_data = r_or;
            FN_XOR:  next_data = r_xor;
            FN_NOR:  next_data = r_nor;
            FN_SHL,
            FN_SHR,
            FN_SHRA: next_data = r_shift;
            FN_EXTB: next_data = ext_b;
            FN_EXTH: next_data = ext_h;
            default: next_illegal = 1'b1;
        endcase
    end

    // Output state transitions: T_ACCEPT / T_DRAIN
    always_comb begin
        unique case (state_q)
            OUT_IDLE:  state_d = in_valid ? OUT_VALID : OUT_IDLE;
            OUT_VALID: state_d = in_valid ? OUT_VALID : OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q    <= '0;
            illegal_q <= 1'b0;
        end else if (in_valid) begin
            data_q    <= next_data;
            illegal_q <= next_illegal;
        end
    end

    assign res_valid   = (state_q == OUT_VALID);
    assign res_data    = data_q;
    assign res_illegal = illegal_q;
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
    parameter int W  = 32,
    parameter int FW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [FW-1:0] fn,
    input logic [W-1:0]  opa,
    input logic          res_valid,
    input logic [W-1:0]  res_data,
    input logic          res_illegal
);
    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);
    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_data) && $stable(res_illegal)));
    assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (res_data == '0));
    assert_illegal_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn >= FW'(13)) |=> res_illegal);
    assert_illegal_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn < FW'(13)) |=> !res_illegal);
    assert_cmp_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (fn == FW'(2) || fn == FW'(3))) |=> (res_data[W-1:1] == '0));
    assert_extb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fn == FW'(11)) |=> (res_data == {{(W-8){$past(opa[7])}}, $past(opa[7:0])}));
endmodule

bind alu_top alu_chk #(.W(W), .FW(FW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fn(fn), .opa(opa),
    .res_valid(res_valid), .res_data(res_data), .res_illegal(res_illegal)
);

// File: tb/sim_alu_top.sv
`timescale 1ns/1ps
module sim_alu_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  fn;
    logic [31:0] opa, opb, imm;
    logic        use_imm;
    logic        res_valid;
    logic [31:0] res_data;
    logic        res_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    alu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fn(fn),
        .opa(opa), .opb(opb), .imm(imm), .use_imm(use_imm),
        .res_valid(res_valid), .res_data(res_data), .res_illegal(res_illegal)
    );

    function automatic logic [31:0] model(input logic [3:0] f, input logic [31:0] a,
                                          input logic [31:0] b);
        case (f)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return (a < b) ? 32'd1 : 32'd0;
            4'd3:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd4:  return a & b;
            4'd5:  return a | b;
            4'd6:  return a ^ b;
            4'd7:  return ~(a | b);
            4'd8:  return a << b[4:0];
            4'd9:  return a >> b[4:0];
            4'd10: return $unsigned($signed(a) >>> b[4:0]);
            4'd11: return {{24{a[7]}}, a[7:0]};
            4'd12: return {{16{a[15]}}, a[15:0]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] f);
        if (f <= 4'd1) return "R1";
        if (f <= 4'd3) return "R2";
        if (f <= 4'd7) return "R3";
        if (f <= 4'd10) return "R4";
        if (f <= 4'd12) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation on a negedge, then sample one negedge later.
    task automatic issue(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] im, input logic ui, input string tag);
        logic [31:0] sec;
        @(negedge clk);
        in_valid = 1'b1; fn = f; opa = a; opb = b; imm = im; use_imm = ui;
        sec = ui ? im : b;
        @(negedge clk);
        check({tag, " data ", req_of(f)}, res_data, model(f, a, sec));
        check({tag, " illegal R6"}, {31'd0, res_illegal}, {31'd0, f >= 4'd13});
        check({tag, " valid R8"}, {31'd0, res_valid}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R8 actual=timeout expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd4711));
        rst_n = 1'b0; in_valid = 1'b1; fn = 4'd0;
        opa = 32'hFFFF_FFFF; opb = 32'h1; imm = 32'h0; use_imm = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("reset valid R9", {31'd0, res_valid}, 32'd0);
        check("reset data R9", res_data, 32'd0);
        check("reset illegal R9", {31'd0, res_illegal}, 32'd0);
        rst_n = 1'b1; in_valid = 1'b0;

        // Directed corners
        issue(4'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0, "add wrap R1");
        issue(4'd1, 32'h0, 32'h1, 32'h0, 1'b0, "sub wrap R1");
        issue(4'd2, 32'h8000_0000, 32'h1, 32'h0, 1'b0, "ltu big R2");
        issue(4'd3, 32'h8000_0000, 32'h1, 32'h0, 1'b0, "lts neg R2");
        issue(4'd3, 32'h5, 32'h5, 32'h0, 1'b0, "lts equal R2");
        issue(4'd7, 32'h0F0F_0000, 32'h00F0_F000, 32'h0, 1'b0, "nor R3");
        issue(4'd10, 32'h8000_0010, 32'h1F, 32'h0, 1'b0, "sra 31 R4");
        issue(4'd8, 32'h1, 32'hFFFF_FFE3, 32'h0, 1'b0, "shl masked amt R4");
        issue(4'd9, 32'hF000_0000, 32'h7, 32'h0000_0124, 1'b1, "shr imm masked R4 R7");
        issue(4'd11, 32'h1234_5680, 32'hFFFF_FFFF, 32'h0, 1'b0, "extb R5");
        issue(4'd12, 32'h0000_7FFF, 32'h1234_5678, 32'h0, 1'b1, "exth R5");
        issue(4'd0, 32'h10, 32'h9999_9999, 32'h20, 1'b1, "imm select R7");
        issue(4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 1'b0, "illegal 13 R6");
        issue(4'd15, 32'h1, 32'h2, 32'h3, 1'b1, "illegal 15 R6");

        // R8: idle cycle after an illegal result, with inputs changing
        @(negedge clk);
        in_valid = 1'b0; fn = 4'd0; opa = 32'h1234; opb = 32'h1;
        @(negedge clk);
        check("idle valid R8", {31'd0, res_valid}, 32'd0);
        check("idle hold data R8", res_data, 32'd0);
        check("idle hold illegal R8", {31'd0, res_illegal}, 32'd1);

        issue(4'd4, 32'hDEAD_BEEF, 32'hFFFF_0000, 32'h0, 1'b0, "and R3");
        @(negedge clk);
        in_valid = 1'b0; fn = 4'd5; opa = 32'h0; opb = 32'h0;
        held = 32'hDEAD_0000;
        @(negedge clk);
        check("idle hold legal R8", res_data, held);

        // Constrained random: all codes, mixed operand selection
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  f;
            logic [31:0] a, b, im;
            f  = 4'($urandom_range(0, 15));
            a  = $urandom;
            b  = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 40)) : $urandom;
            im = $urandom;
            issue(f, a, b, im, 1'($urandom_range(0, 1)), "random");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule